// File: doc/BRIEF.md
# Rank-Aware Row-Hit Request Picker

This block picks one request from a memory controller's pending queue each cycle. The queue holds up to `QDEPTH` entries, stored oldest first at index 0, and each entry names a rank, a bank within that rank and a row. A neighbouring bank-state block supplies three things. The first is a table giving the open row of every bank, with a valid bit for each. The second is the rank used by the last data burst. The third is a mask of the banks that can be prepared soonest. The controller also provides a flag saying the command direction (read or write) has just changed.

The picker prefers a row hit to the rank of the previous burst, which keeps the data bus from paying a rank-switch bubble. It keeps a row hit to another rank as the next choice. After that it takes the oldest non-hit entry whose bank is among the earliest to prepare. When the direction has just changed, a bus bubble is paid anyway, so the rank preference is dropped. A configuration bit selects plain first-come-first-served behaviour. The choice is made combinationally and registered, so the index and valid signal appear one clock after the inputs.

Top module: `rank_pick`

## Requirements
- R1: During reset (`rst_n` low at a clock edge), the following edge leaves `pick_valid` = 0 and `pick_idx` = 0.
- R2: Outputs are registered: inputs sampled at one rising edge appear after that edge. `pick_valid` is 1 exactly when `q_count` was non-zero; with `q_count` = 0 it is 0 and `pick_idx` is 0.
- R3: An entry is a row hit only when bank id `rank*NBANK+bank` has its `open_vld` bit set and its `open_row` field (bits `id*ROWW +: ROWW`) equals the entry's row; a bank whose `open_vld` bit is clear never makes a hit.
- R4: With `fcfs_mode` = 0 and `switched` = 0, the oldest row hit whose rank equals `active_rank` is chosen, even if a row hit to another rank is older.
- R5: With `fcfs_mode` = 0 and `switched` = 1, the oldest row hit to any rank is chosen.
- R6: With `fcfs_mode` = 0, `switched` = 0 and no same-rank hit, the oldest row hit to another rank is chosen, even if an older non-hit entry has its early-mask bit set.
- R7: With `fcfs_mode` = 0 and no row hit at all, the oldest entry whose bit `rank*NBANK+bank` is set in `early_mask` is chosen.
- R8: When no entry qualifies under R4 to R7, index 0 (the oldest entry) is chosen.
- R9: With `fcfs_mode` = 1, index 0 is chosen whatever the other inputs are.
- R10: Entries at index `q_count` or above are ignored; the chosen index is below `q_count` when `q_count` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fcfs_mode | input | 1 | 1 selects plain oldest-first picking |
| switched | input | 1 | Command direction has just changed |
| active_rank | input | RKW | Rank of the previous data burst |
| q_count | input | CNTW | Number of valid entries, filled from index 0 |
| q_rank | input | QDEPTH*RKW | Rank of each entry, entry i at bits i*RKW |
| q_bank | input | QDEPTH*BKW | Bank of each entry, entry i at bits i*BKW |
| q_row | input | QDEPTH*ROWW | Row of each entry, entry i at bits i*ROWW |
| open_vld | input | NRANK*NBANK | Bank has an open row |
| open_row | input | NRANK*NBANK*ROWW | Open row of each bank |
| early_mask | input | NRANK*NBANK | Banks that can be prepared soonest |
| pick_idx | output | IDXW | Index of the chosen entry |
| pick_valid | output | 1 | A choice was made |

## Verification
The assertions assume that `q_count` never exceeds `QDEPTH` and that every live entry's rank and bank, and `active_rank`, are within the configured counts. Bank ids out of range would index past the open-row table. The random stimulus draws ranks, banks and the active rank only from legal ranges, and draws `q_count` from 0 to `QDEPTH`. It uses a two-bit row space so that hits, misses, mixed ranks and empty banks all occur often. Directed cases set up each priority level against an older entry of a lower level.

// File: rtl/rank_pick_pkg.sv
// Package: shared helpers for the rank-aware picker.
// Assumes: widths below are used for index and field sizing only.
package rank_pick_pkg;

    // Width of a field that must hold values 0..n-1 (at least one bit).
    function automatic int fld_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rp_entry_eval.sv
// Module: per-entry classification of queued requests.
// For each entry it reports liveness, row hit, same-rank and early-bank
// membership. Assumes rank < NRANK and bank < NBANK for live entries.
module rp_entry_eval
    import rank_pick_pkg::*;
#(
    parameter int QDEPTH = 8,
    parameter int NRANK  = 2,
    parameter int NBANK  = 4,
    parameter int ROWW   = 4,
    localparam int RKW   = fld_w(NRANK),
    localparam int BKW   = fld_w(NBANK),
    localparam int NB    = NRANK * NBANK,
    localparam int IDW   = fld_w(NB),
    localparam int CNTW  = $clog2(QDEPTH + 1)
) (
    input  logic [RKW-1:0]         active_rank,
    input  logic [CNTW-1:0]        q_count,
    input  logic [QDEPTH*RKW-1:0]  q_rank,
    input  logic [QDEPTH*BKW-1:0]  q_bank,
    input  logic [QDEPTH*ROWW-1:0] q_row,
    input  logic [NB-1:0]          open_vld,
    input  logic [NB*ROWW-1:0]     open_row,
    input  logic [NB-1:0]          early_mask,
    output logic [QDEPTH-1:0]      live_v,
    output logic [QDEPTH-1:0]      hit_v,
    output logic [QDEPTH-1:0]      same_v,
    output logic [QDEPTH-1:0]      early_v
);

    for (genvar i = 0; i < QDEPTH; i++) begin : g_ent
        logic [RKW-1:0] rk;
        logic [BKW-1:0] bk;
        logic [IDW-1:0] bid;
        assign rk  = q_rank[i*RKW +: RKW];
        assign bk  = q_bank[i*BKW +: BKW];
        assign bid = IDW'(rk) * IDW'(NBANK) + IDW'(bk);

        // classify one entry against the bank table
        always_comb begin
            live_v[i]  = CNTW'(i) < q_count;
            hit_v[i]   = open_vld[bid] &&
                         (open_row[bid*ROWW +: ROWW] == q_row[i*ROWW +: ROWW]);
            same_v[i]  = (rk == active_rank);
            early_v[i] = early_mask[bid];
        end
    end

endmodule

// File: rtl/rp_first_find.sv
// Module: lowest-index set bit finder (oldest-first priority).
// Assumes index 0 is the highest priority; idx is 0 when nothing is set.
module rp_first_find #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    // scan from the youngest so the oldest set bit is left last
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/rank_pick.sv
// Module: rank-aware row-hit-first request picker, registered output.
// Priority: preferred row hit, other-rank row hit, early-bank non-hit,
// then the head. Assumes entries 0..q_count-1 are valid, oldest at 0.
module rank_pick
    import rank_pick_pkg::*;
#(
    parameter int QDEPTH = 8,
    parameter int NRANK  = 2,
    parameter int NBANK  = 4,
    parameter int ROWW   = 4,
    localparam int RKW   = fld_w(NRANK),
    localparam int BKW   = fld_w(NBANK),
    localparam int NB    = NRANK * NBANK,
    localparam int IDXW  = fld_w(QDEPTH),
    localparam int CNTW  = $clog2(QDEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fcfs_mode,
    input  logic                   switched,
    input  logic [RKW-1:0]         active_rank,
    input  logic [CNTW-1:0]        q_count,
    input  logic [QDEPTH*RKW-1:0]  q_rank,
    input  logic [QDEPTH*BKW-1:0]  q_bank,
    input  logic [QDEPTH*ROWW-1:0] q_row,
    input  logic [NB-1:0]          open_vld,
    input  logic [NB*ROWW-1:0]     open_row,
    input  logic [NB-1:0]          early_mask,
    output logic [IDXW-1:0]        pick_idx,
    output logic                   pick_valid
);

    logic [QDEPTH-1:0] live_v, hit_v, same_v, early_v;
    logic [QDEPTH-1:0] pref_req, other_req, early_req;
    logic              pref_f, other_f, early_f;
    logic [IDXW-1:0]   pref_i, other_i, early_i;
    logic [IDXW-1:0]   nxt_idx;

    rp_entry_eval #(
        .QDEPTH(QDEPTH), .NRANK(NRANK), .NBANK(NBANK), .ROWW(ROWW)
    ) u_eval (
        .active_rank(active_rank), .q_count(q_count),
        .q_rank(q_rank), .q_bank(q_bank), .q_row(q_row),
        .open_vld(open_vld), .open_row(open_row), .early_mask(early_mask),
        .live_v(live_v), .hit_v(hit_v), .same_v(same_v), .early_v(early_v)
    );

    // build the three priority request vectors
    always_comb begin
        pref_req  = live_v & hit_v & (switched ? {QDEPTH{1'b1}} : same_v);
        other_req = live_v & hit_v & ~same_v;
        early_req = live_v & ~hit_v & early_v;
    end

    rp_first_find #(.N(QDEPTH), .IW(IDXW)) u_ff_pref (
        .req(pref_req), .found(pref_f), .idx(pref_i));
    rp_first_find #(.N(QDEPTH), .IW(IDXW)) u_ff_other (
        .req(other_req), .found(other_f), .idx(other_i));
    rp_first_find #(.N(QDEPTH), .IW(IDXW)) u_ff_early (
        .req(early_req), .found(early_f), .idx(early_i));

    // resolve priority levels, head as the fallback
    always_comb begin
        if (fcfs_mode)    nxt_idx = '0;
        else if (pref_f)  nxt_idx = pref_i;
        else if (other_f) nxt_idx = other_i;
        else if (early_f) nxt_idx = early_i;
        else              nxt_idx = '0;
    end

    // register the choice
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pick_idx   <= '0;
            pick_valid <= 1'b0;
        end else begin
            pick_idx   <= nxt_idx;
            pick_valid <= (q_count != '0);
        end
    end

endmodule

// File: rtl/rank_pick_chk.sv
// Module: assertion checker for rank_pick, bound to every instance.
// Keeps a one-cycle copy of the inputs and relates it to the outputs.
module rank_pick_chk
    import rank_pick_pkg::*;
#(
    parameter int QDEPTH = 8,
    parameter int NRANK  = 2,
    parameter int NBANK  = 4,
    parameter int ROWW   = 4,
    localparam int RKW   = fld_w(NRANK),
    localparam int BKW   = fld_w(NBANK),
    localparam int NB    = NRANK * NBANK,
    localparam int IDXW  = fld_w(QDEPTH),
    localparam int CNTW  = $clog2(QDEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fcfs_mode,
    input  logic                   switched,
    input  logic [RKW-1:0]         active_rank,
    input  logic [CNTW-1:0]        q_count,
    input  logic [QDEPTH*RKW-1:0]  q_rank,
    input  logic [QDEPTH*BKW-1:0]  q_bank,
    input  logic [QDEPTH*ROWW-1:0] q_row,
    input  logic [NB-1:0]          open_vld,
    input  logic [NB*ROWW-1:0]     open_row,
    input  logic [NB-1:0]          early_mask,
    input  logic [IDXW-1:0]        pick_idx,
    input  logic                   pick_valid
);

    logic                   d_ok, d_fcfs;
    logic [CNTW-1:0]        d_cnt;
    logic [QDEPTH*RKW-1:0]  d_rank;
    logic [QDEPTH*BKW-1:0]  d_bank;
    logic [QDEPTH*ROWW-1:0] d_row;
    logic [NB-1:0]          d_ovld;
    logic [NB*ROWW-1:0]     d_orow;
    logic                   d_anyhit, d_pickhit;

    // remember whether the last edge was out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) d_ok <= 1'b0;
        else        d_ok <= 1'b1;
    end

    // one-cycle copy of the inputs that decide a row hit
    always_ff @(posedge clk) begin
        d_fcfs <= fcfs_mode;
        d_cnt  <= q_count;
        d_rank <= q_rank;
        d_bank <= q_bank;
        d_row  <= q_row;
        d_ovld <= open_vld;
        d_orow <= open_row;
    end

    // hit status of the copied queue and of the chosen entry
    always_comb begin
        d_anyhit  = 1'b0;
        d_pickhit = 1'b0;
        for (int i = 0; i < QDEPTH; i++) begin
            int  b;
            logic h;
            b = int'(d_rank[i*RKW +: RKW]) * NBANK + int'(d_bank[i*BKW +: BKW]);
            h = (b < NB) && d_ovld[b] &&
                (d_orow[b*ROWW +: ROWW] == d_row[i*ROWW +: ROWW]);
            if (h && (i < int'(d_cnt))) d_anyhit = 1'b1;
            if (h && (i == int'(pick_idx))) d_pickhit = 1'b1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!pick_valid && pick_idx == '0));

    p_empty_novalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == '0) |=> (!pick_valid && pick_idx == '0));

    p_busy_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count != '0) |=> pick_valid);

    p_fcfs_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fcfs_mode |=> (pick_idx == '0));

    p_pick_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count != '0) |=> (CNTW'(pick_idx) < $past(q_count)));

    p_count_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(q_count) <= QDEPTH));

    // R4 R5 R6: a row hit in the queue means a row hit is chosen
    p_hit_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (d_ok && !d_fcfs && d_anyhit) |-> d_pickhit);

endmodule

bind rank_pick rank_pick_chk #(
    .QDEPTH(QDEPTH), .NRANK(NRANK), .NBANK(NBANK), .ROWW(ROWW)
) u_rank_pick_chk (.*);

// File: tb/test_rank_pick.sv
// Bench: directed priority cases plus seeded random stimulus for rank_pick.
module test_rank_pick;
    localparam int CLK_PERIOD = 10;
    localparam int QD   = 8;
    localparam int NR   = 2;
    localparam int NBK  = 4;
    localparam int RW   = 4;
    localparam int RKW  = 1;
    localparam int BKW  = 2;
    localparam int NB   = NR * NBK;
    localparam int IDXW = 3;
    localparam int CNTW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fcfs_mode, switched;
    logic [RKW-1:0] active_rank;
    logic [CNTW-1:0] q_count;
    logic [QD*RKW-1:0] q_rank;
    logic [QD*BKW-1:0] q_bank;
    logic [QD*RW-1:0] q_row;
    logic [NB-1:0] open_vld, early_mask;
    logic [NB*RW-1:0] open_row;
    logic [IDXW-1:0] pick_idx;
    logic pick_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int rk[QD], bk[QD], rw[QD], orow[NB];
    bit ov[NB], msk[NB];
    int act, cnt;
    bit sw, fc;

    rank_pick #(.QDEPTH(QD), .NRANK(NR), .NBANK(NBK), .ROWW(RW)) i_rank_pick (
        .clk(clk), .rst_n(rst_n), .fcfs_mode(fcfs_mode), .switched(switched),
        .active_rank(active_rank), .q_count(q_count), .q_rank(q_rank),
        .q_bank(q_bank), .q_row(q_row), .open_vld(open_vld),
        .open_row(open_row), .early_mask(early_mask),
        .pick_idx(pick_idx), .pick_valid(pick_valid));

    always #(CLK_PERIOD/2) clk = ~clk;

    // bench model of the selection rules
    function automatic int model_idx();
        int id;
        bit hit;
        if (fc) return 0;
        for (int lvl = 0; lvl < 3; lvl++) begin
            for (int i = 0; i < cnt; i++) begin
                id  = rk[i] * NBK + bk[i];
                hit = ov[id] && (orow[id] == rw[i]);
                if (lvl == 0 && hit && (sw || rk[i] == act)) return i;
                if (lvl == 1 && hit && rk[i] != act) return i;
                if (lvl == 2 && !hit && msk[id]) return i;
            end
        end
        return 0;
    endfunction

    task automatic drive();
        fcfs_mode = fc; switched = sw;
        active_rank = RKW'(act); q_count = CNTW'(cnt);
        for (int i = 0; i < QD; i++) begin
            q_rank[i*RKW +: RKW] = RKW'(rk[i]);
            q_bank[i*BKW +: BKW] = BKW'(bk[i]);
            q_row[i*RW +: RW]    = RW'(rw[i]);
        end
        for (int b = 0; b < NB; b++) begin
            open_vld[b] = ov[b]; early_mask[b] = msk[b];
            open_row[b*RW +: RW] = RW'(orow[b]);
        end
    endtask

    task automatic expect_out(string req, bit ev, int ei);
        checks++;
        if (pick_valid !== ev || int'(pick_idx) != ei) begin
            errors++;
            $display("FAIL %s: valid/idx %0b/%0d expected %0b/%0d",
                     req, pick_valid, pick_idx, ev, ei);
        end
    endtask

    // apply inputs at a falling edge, sample one full cycle later
    task automatic run(string req, int ei);
        drive();
        @(posedge clk);
        @(negedge clk);
        expect_out(req, cnt != 0, (cnt != 0) ? ei : 0);
    endtask

    task automatic clear_all();
        fc = 0; sw = 0; act = 0; cnt = QD;
        for (int i = 0; i < QD; i++) begin rk[i] = 0; bk[i] = i % NBK; rw[i] = i; end
        for (int b = 0; b < NB; b++) begin ov[b] = 0; msk[b] = 0; orow[b] = 0; end
    endtask

    task automatic setup_hits();
        clear_all();
        ov[1] = 1; orow[1] = 5; rk[5] = 0; bk[5] = 1; rw[5] = 5;
        ov[5] = 1; orow[5] = 2; rk[2] = 1; bk[2] = 1; rw[2] = 2;
    endtask

    initial begin
        clear_all();
        drive();
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_out("R1", 0, 0);
        rst_n = 1'b1;

        clear_all();   run("R8", 0);
        setup_hits();  run("R4", 5);
        setup_hits(); sw = 1; run("R5", 2);
        setup_hits(); rw[5] = 9; msk[1] = 1; run("R6", 2);
        setup_hits(); rw[5] = 9; rw[2] = 7; msk[1] = 1; run("R7", 1);
        clear_all(); orow[1] = 1; run("R3 closed bank", 0);
        clear_all(); ov[1] = 1; orow[1] = 1; run("R3 open bank", 1);
        setup_hits(); fc = 1; msk[0] = 1; run("R9", 0);
        setup_hits(); cnt = 5; run("R10", 2);
        setup_hits(); cnt = 2; msk[5] = 1; run("R10 masked tail", 0);
        setup_hits(); cnt = 0; run("R2 empty", 0);
        setup_hits(); act = 1; run("R4 rank1", 2);

        for (int n = 0; n < 3000; n++) begin
            fc = ($urandom % 8) == 0;
            sw = $urandom % 2;
            act = $urandom % NR;
            cnt = $urandom % (QD + 1);
            for (int i = 0; i < QD; i++) begin
                rk[i] = $urandom % NR; bk[i] = $urandom % NBK; rw[i] = $urandom % 4;
            end
            for (int b = 0; b < NB; b++) begin
                ov[b] = $urandom % 2; msk[b] = ($urandom % 4) == 0; orow[b] = $urandom % 4;
            end
            run("R2-R10 random", model_idx());
        end
        done = 1;
    end

    initial begin
        void'($urandom(32'd1729));
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule